// File: doc/BRIEF.md
# Late-Write Flow-Through Synchronous SRAM Core

This block is a synthesizable single-port synchronous memory, 1K words of 18 bits by default, organised as two 9-bit byte lanes. A command is taken on a rising clock edge through a load or advance control. Read data flows out combinationally from the registered address, so it is valid in the cycle that follows the command edge. Write data arrives one cycle later than its command. This late write matches the read latency, so reads and writes can follow each other in any order without an idle bus cycle.

Written data first lands in a one-entry write buffer. It reaches the storage array only when the next write's data displaces it. A read that hits the buffered address merges the buffered bytes over the array word. Bursts of four reuse the two low address bits in either linear or interleaved order. A clock-enable input freezes the whole pipeline. An asynchronous output enable gates the data outputs.

Top module: `sram_lw_core`

## Requirements
- R1: A load cycle (adv_ld=0, device selected, rd_wr_n=1) at edge k gives rd_valid=1, and the word at addr on rd_data (oe_n=0), during the cycle that follows edge k.
- R2: A load cycle with rd_wr_n=0 registers a write of addr. The bytes on wdata are taken at the next enabled edge. bwe_n[0]=0 enables bits 8:0 and bwe_n[1]=0 enables bits 17:9; both low writes the full word and both high writes nothing.
- R3: A read of the address whose data was taken at the same edge, or that is still held in the write buffer, returns that data merged over the stored word, with no idle cycle between write and read.
- R4: The device is selected only when cs0_n=0, cs1=1 and cs2_n=0 on a load cycle; any other pattern is a deselect, giving rd_valid=0 and rd_oe=0 in the next cycle.
- R5: On advance cycles (adv_ld=1), cs0_n, cs1, cs2_n, rd_wr_n and addr are ignored. The previous operation (read, write or deselect) continues at the next burst address, and bwe_n is sampled again for burst writes.
- R6: Burst addresses keep addr[9:2]. With burst_lin=1 the low two bits on step n are start+n mod 4; with burst_lin=0 they are start XOR n; the fifth access wraps to the start.
- R7: With cke_n=1 no state changes on the edge: no command is taken, pending write data is not captured, and the outputs hold.
- R8: rd_oe = rd_valid and not oe_n, with no clock involved, and rd_data is zero whenever rd_oe is low.
- R9: rd_valid is low in the cycle after a write cycle or a deselect cycle.
- R10: After reset rd_valid=0, rd_oe=0, no write is pending and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cke_n | input | 1 | Clock enable, active low; high stalls everything |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write on load cycles |
| bwe_n | input | 2 | Byte write enables, active low, bit 0 = low byte |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | 10 | Word address |
| wdata | input | 18 | Write data, one cycle after the write command |
| rd_data | output | 18 | Read data, zero when not driven |
| rd_valid | output | 1 | Current cycle carries a selected read |
| rd_oe | output | 1 | Data outputs are driven |

## Verification
Every read result is due in the cycle right after the edge that took its command. The bench drives each command, waits for that edge, and samples one nanosecond later, before driving the next one. Write data is placed on wdata in the cycle after its write command, together with whatever command follows, so forwarding and back-to-back order are exercised at the real pipeline distance. Stalled edges are counted explicitly, and output-enable checks are made between edges because that path has no clock.

// File: rtl/sram_lw_pkg.sv
`timescale 1ns/1ps
package sram_lw_pkg;

  // Operation held in the command stage for the current bus cycle.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Burst wraps over four words held in the low address bits.
  localparam int BURST_BITS = 2;

  // Low address bits for a given step of a burst.
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] step,
    input logic                  lin
  );
    return lin ? (start + step) : (start ^ step);
  endfunction

endpackage

// File: rtl/sram_lw_cmd.sv
`timescale 1ns/1ps
module sram_lw_cmd
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sel,
  input  logic              rd_wr_n,
  input  logic              adv_ld,
  input  logic [NBYTES-1:0] bwe_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [NBYTES-1:0] cur_be_n
);
  localparam int BB = BURST_BITS;

  logic [BB-1:0] base_lo;
  logic [BB-1:0] step_q;
  logic [BB-1:0] step_nxt;
  logic          load_ev;
  logic          adv_ev;
  op_e           load_op;

  assign load_ev  = en & ~adv_ld;
  assign adv_ev   = en & adv_ld;
  assign step_nxt = step_q + BB'(1);

  always_comb begin
    if (!sel)         load_op = OP_NONE;
    else if (rd_wr_n) load_op = OP_RD;
    else              load_op = OP_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      cur_addr <= '0;
      cur_be_n <= '1;
      base_lo  <= '0;
      step_q   <= '0;
    end else if (load_ev) begin
      op_q     <= load_op;
      cur_addr <= addr;
      cur_be_n <= bwe_n;
      base_lo  <= addr[BB-1:0];
      step_q   <= '0;
    end else if (adv_ev) begin
      cur_addr[BB-1:0] <= burst_low(base_lo, step_nxt, burst_lin);
      cur_be_n         <= bwe_n;
      step_q           <= step_nxt;
    end
  end

  assert_adv_keeps_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> op_q == $past(op_q));

  assert_adv_keeps_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> cur_addr[ADDR_W-1:BB] == $past(cur_addr[ADDR_W-1:BB]));

  assert_desel_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !sel) |=> op_q == OP_NONE);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(op_q) && $stable(cur_addr) && $stable(step_q)));

endmodule

// File: rtl/sram_lw_wbuf.sv
`timescale 1ns/1ps
module sram_lw_wbuf #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES-1:0]        be_n,
  input  logic [BYTE_W*NBYTES-1:0] wdata,
  output logic                     buf_vld,
  output logic [ADDR_W-1:0]        buf_addr,
  output logic [NBYTES-1:0]        buf_be_n,
  output logic [BYTE_W*NBYTES-1:0] buf_data,
  output logic                     commit
);
  // The held entry is pushed into the array when new write data displaces it.
  assign commit = cap & buf_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_addr <= '0;
      buf_be_n <= '1;
      buf_data <= '0;
    end else if (cap) begin
      buf_vld  <= 1'b1;
      buf_addr <= addr;
      buf_be_n <= be_n;
      buf_data <= wdata;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (buf_vld && buf_addr == $past(addr) && buf_data == $past(wdata)
             && buf_be_n == $past(be_n)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(buf_data) && $stable(buf_addr)));

endmodule

// File: rtl/sram_lw_array.sv
`timescale 1ns/1ps
module sram_lw_array #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NBYTES-1:0]        wbe_n,
  input  logic [BYTE_W*NBYTES-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [BYTE_W*NBYTES-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wbe_n[b]) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
    end

    assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
  end

endmodule

// File: rtl/sram_lw_core.sv
`timescale 1ns/1ps
module sram_lw_core
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     cs0_n,
  input  logic                     cs1,
  input  logic                     cs2_n,
  input  logic                     rd_wr_n,
  input  logic [NBYTES-1:0]        bwe_n,
  input  logic                     adv_ld,
  input  logic                     oe_n,
  input  logic                     burst_lin,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W*NBYTES-1:0] wdata,
  output logic [BYTE_W*NBYTES-1:0] rd_data,
  output logic                     rd_valid,
  output logic                     rd_oe
);
  localparam int DW = BYTE_W * NBYTES;

  // Buffered bytes override the stored word where their enables are active.
  function automatic logic [DW-1:0] fwd_merge(
    input logic [DW-1:0]     stored,
    input logic [DW-1:0]     pend,
    input logic [NBYTES-1:0] pend_be_n
  );
    logic [DW-1:0] res;
    res = stored;
    for (int b = 0; b < NBYTES; b++) begin
      if (!pend_be_n[b]) res[b*BYTE_W +: BYTE_W] = pend[b*BYTE_W +: BYTE_W];
    end
    return res;
  endfunction

  logic              en;
  logic              sel;
  op_e               op_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [NBYTES-1:0] cur_be_n;
  logic              cap;
  logic              buf_vld;
  logic [ADDR_W-1:0] buf_addr;
  logic [NBYTES-1:0] buf_be_n;
  logic [DW-1:0]     buf_data;
  logic              commit;
  logic [DW-1:0]     arr_rdata;
  logic              fwd_hit;
  logic [DW-1:0]     read_word;

  assign en  = ~cke_n;
  assign sel = ~cs0_n & cs1 & ~cs2_n;

  sram_lw_cmd #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sel       (sel),
    .rd_wr_n   (rd_wr_n),
    .adv_ld    (adv_ld),
    .bwe_n     (bwe_n),
    .burst_lin (burst_lin),
    .addr      (addr),
    .op_q      (op_q),
    .cur_addr  (cur_addr),
    .cur_be_n  (cur_be_n)
  );

  // Late write: data belonging to the registered write is taken on this edge.
  assign cap = en & (op_q == OP_WR);

  sram_lw_wbuf #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .addr     (cur_addr),
    .be_n     (cur_be_n),
    .wdata    (wdata),
    .buf_vld  (buf_vld),
    .buf_addr (buf_addr),
    .buf_be_n (buf_be_n),
    .buf_data (buf_data),
    .commit   (commit)
  );

  sram_lw_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (buf_addr),
    .wbe_n (buf_be_n),
    .wdata (buf_data),
    .raddr (cur_addr),
    .rdata (arr_rdata)
  );

  assign fwd_hit   = buf_vld & (buf_addr == cur_addr);
  assign read_word = fwd_hit ? fwd_merge(arr_rdata, buf_data, buf_be_n) : arr_rdata;

  assign rd_valid = (op_q == OP_RD);
  assign rd_oe    = rd_valid & ~oe_n;
  assign rd_data  = rd_oe ? read_word : '0;

  assert_read_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld && sel && rd_wr_n) |=> rd_valid);

  assert_fwd_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !adv_ld && sel && rd_wr_n && addr == cur_addr) |=> fwd_hit);

  assert_desel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld && !sel) |=> (!rd_valid && !rd_oe));

  assert_no_valid_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld && sel && !rd_wr_n) |=> !rd_valid);

  always_comb begin
    assert_oe_gate_R8: assert (rd_oe || rd_data == '0);
  end

endmodule

// File: tb/sim_sram_lw_core.sv
`timescale 1ns/1ps
module sim_sram_lw_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_n = 1'b0;
  logic        cs0_n = 1'b1;
  logic        cs1 = 1'b0;
  logic        cs2_n = 1'b1;
  logic        rd_wr_n = 1'b1;
  logic [1:0]  bwe_n = 2'b11;
  logic        adv_ld = 1'b0;
  logic        oe_n = 1'b0;
  logic        burst_lin = 1'b0;
  logic [9:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rd_data;
  logic        rd_valid;
  logic        rd_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic [17:0] model [1024];

  always #2 clk = ~clk;

  sram_lw_core u0 (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .rd_wr_n(rd_wr_n), .bwe_n(bwe_n), .adv_ld(adv_ld),
    .oe_n(oe_n), .burst_lin(burst_lin), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_oe(rd_oe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] upd(input logic [17:0] old, input logic [17:0] d,
                                      input logic [1:0] be_n);
    logic [17:0] m;
    m = {{9{~be_n[1]}}, {9{~be_n[0]}}};
    return (old & ~m) | (d & m);
  endfunction

  task automatic ld(input logic s, input logic rw, input logic [9:0] a, input logic [1:0] be);
    adv_ld = 1'b0;
    {cs0_n, cs1, cs2_n} = s ? 3'b010 : 3'b111;
    rd_wr_n = rw;
    addr = a;
    bwe_n = be;
  endtask

  // Advance: scramble every input that must be ignored.
  task automatic adv(input logic [1:0] be);
    adv_ld = 1'b1;
    {cs0_n, cs1, cs2_n} = 3'b101;
    rd_wr_n = ~rd_wr_n;
    addr = addr ^ 10'h2A5;
    bwe_n = be;
  endtask

  task automatic put(input logic [9:0] a, input logic [17:0] d, input logic [1:0] be);
    wdata = d;
    model[a] = upd(model[a], d, be);
  endtask

  task automatic t_reset();
    chk("R10 rd_valid after reset", 32'(rd_valid), 0);
    chk("R10 rd_oe after reset", 32'(rd_oe), 0);
  endtask

  task automatic t_back_to_back();
    ld(1, 0, 10'h010, 2'b00); tick();
    chk("R9 valid low after write", 32'(rd_valid), 0);
    put(10'h010, 18'h2AB5C, 2'b00); ld(1, 1, 10'h010, 2'b11); tick();
    chk("R1 read valid", 32'(rd_valid), 1);
    chk("R3 forward same edge", 32'(rd_data), 32'(model[10'h010]));
    ld(1, 0, 10'h011, 2'b00); tick();
    chk("R9 valid low after write 2", 32'(rd_valid), 0);
    put(10'h011, 18'h1C3A7, 2'b00); ld(1, 0, 10'h012, 2'b00); tick();
    put(10'h012, 18'h05E91, 2'b00); ld(1, 1, 10'h011, 2'b11); tick();
    chk("R2 committed word", 32'(rd_data), 32'(model[10'h011]));
    ld(1, 1, 10'h012, 2'b11); tick();
    chk("R3 forward from buffer", 32'(rd_data), 32'(model[10'h012]));
    ld(1, 1, 10'h010, 2'b11); tick();
    chk("R1 read older word", 32'(rd_data), 32'(model[10'h010]));
  endtask

  task automatic t_bytes();
    ld(1, 0, 10'h020, 2'b00); tick();
    put(10'h020, 18'h3FFFF, 2'b00); ld(1, 0, 10'h020, 2'b10); tick();
    put(10'h020, 18'h00000, 2'b10); ld(1, 1, 10'h020, 2'b11); tick();
    chk("R2 low byte only", 32'(rd_data), 32'h3FE00);
    ld(1, 0, 10'h020, 2'b01); tick();
    put(10'h020, 18'h2A955, 2'b01); ld(1, 0, 10'h020, 2'b11); tick();
    put(10'h020, 18'h00000, 2'b11); ld(1, 1, 10'h020, 2'b11); tick();
    chk("R2 high byte then none", 32'(rd_data), 32'(model[10'h020]));
    ld(1, 0, 10'h021, 2'b00); tick();
    put(10'h021, 18'h12345, 2'b00); ld(1, 1, 10'h020, 2'b11); tick();
    chk("R2 byte merge in array", 32'(rd_data), 32'(model[10'h020]));
  endtask

  task automatic t_select();
    for (int c = 0; c < 8; c++) begin
      adv_ld = 1'b0;
      {cs0_n, cs1, cs2_n} = 3'(c);
      rd_wr_n = 1'b1;
      addr = 10'h010;
      tick();
      chk($sformatf("R4 rd_valid cs=%0d", c), 32'(rd_valid), (c == 2) ? 1 : 0);
      chk($sformatf("R4 rd_oe cs=%0d", c), 32'(rd_oe), (c == 2) ? 1 : 0);
    end
  endtask

  task automatic t_burst();
    burst_lin = 1'b1;
    ld(1, 0, 10'h106, 2'b00); tick();
    put(10'h106, 18'h11111, 2'b00); adv(2'b00); tick();
    put(10'h107, 18'h22222, 2'b00); adv(2'b00); tick();
    put(10'h104, 18'h33333, 2'b00); adv(2'b00); tick();
    put(10'h105, 18'h04444, 2'b00);
    burst_lin = 1'b0;
    ld(1, 1, 10'h105, 2'b11); tick();
    chk("R6 interleave step0", 32'(rd_data), 32'(model[10'h105]));
    adv(2'b11); tick();
    chk("R6 interleave step1", 32'(rd_data), 32'(model[10'h104]));
    chk("R5 burst read valid", 32'(rd_valid), 1);
    adv(2'b11); tick();
    chk("R6 interleave step2", 32'(rd_data), 32'(model[10'h107]));
    adv(2'b11); tick();
    chk("R6 interleave step3", 32'(rd_data), 32'(model[10'h106]));
    adv(2'b11); tick();
    chk("R6 burst wrap", 32'(rd_data), 32'(model[10'h105]));
    ld(0, 1, 10'h010, 2'b11); tick();
    adv(2'b11); {cs0_n, cs1, cs2_n} = 3'b010; rd_wr_n = 1'b1; tick();
    chk("R5 deselect burst stays quiet", 32'(rd_valid), 0);
  endtask

  task automatic t_stall();
    ld(1, 0, 10'h030, 2'b00); tick();
    cke_n = 1'b1; wdata = 18'h0DEAD; ld(1, 1, 10'h010, 2'b11); tick(); tick();
    chk("R7 stalled command not taken", 32'(rd_valid), 0);
    cke_n = 1'b0;
    put(10'h030, 18'h2C0DE, 2'b00); ld(1, 1, 10'h030, 2'b11); tick();
    chk("R7 data taken after stall", 32'(rd_data), 32'(model[10'h030]));
    cke_n = 1'b1; ld(1, 1, 10'h010, 2'b11); tick();
    chk("R7 output held in stall", 32'(rd_data), 32'(model[10'h030]));
    cke_n = 1'b0;
  endtask

  task automatic t_oe();
    ld(1, 1, 10'h010, 2'b11); tick();
    oe_n = 1'b1; #1;
    chk("R8 rd_oe off", 32'(rd_oe), 0);
    chk("R8 rd_data zero", 32'(rd_data), 0);
    chk("R8 rd_valid unaffected", 32'(rd_valid), 1);
    oe_n = 1'b0; #1;
    chk("R8 rd_oe on", 32'(rd_oe), 1);
    chk("R8 data back", 32'(rd_data), 32'(model[10'h010]));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_back_to_back();
    t_bytes();
    t_select();
    t_burst();
    t_stall();
    t_oe();
    ld(0, 1, 10'h000, 2'b11); tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule